// File: doc/BRIEF.md
# UART Receive Queue with Line Status

This block sits between a UART receiver and its register file. The receiver hands it one entry at a time: an 8-bit character with four error bits above it. A bus read of the data register pops the oldest entry. The block keeps the empty and full flags for the flag register and a receive-level interrupt request. It also latches the error bits of each entry that is read, for the receive-status register.

A queue-enable bit from line control chooses the mode. When it is set, the block is a 16-deep queue. When it is clear, the block holds a single character. A write that changes this bit empties the queue. A line break is stored as an ordinary entry: a zero character with the break bit set.

Occupancy is tracked by a three-state machine. The states are `Q_EMPTY`, `Q_PART` (some entries, room left) and `Q_FULL`. The transitions are:

- *fill*: `Q_EMPTY` to `Q_PART`, or to `Q_FULL` when capacity is 1.
- *top-up*: `Q_PART` to `Q_FULL`, when a lone push reaches capacity.
- *drain*: `Q_PART` to `Q_EMPTY`, when a lone pop takes the last entry.
- *unload*: `Q_FULL` to `Q_PART`, or to `Q_EMPTY` when capacity is 1.
- *flush*: any state to `Q_EMPTY`, when the mode bit changes.
- *hold*: a cycle with both a push and a pop, or with neither, keeps the state.

Top module: `uart_rxq`

## Requirements
- R1: After reset the queue is empty and in single-entry mode: `empty`=1, `full`=0, `irq`=0, `rx_ready`=1, `ovr`=0, `status`=0.
- R2: In queue mode (`fen`=1) up to 16 entries are accepted. `full` rises and `rx_ready` falls in the cycle after the 16th push, not earlier; `full` and `empty` are never both 1.
- R3: In single-entry mode one push sets `full` and drops `rx_ready`. A read clears `full`.
- R4: A push (`push_valid` or `brk_event`) while `rx_ready`=0 leaves the contents unchanged. It raises `ovr` for exactly the next cycle.
- R5: A read while empty leaves `rd_entry` and the occupancy unchanged, and `empty` stays 1.
- R6: Every read copies bits 11:8 of the entry shown on `rd_entry` into `status`, visible after that clock edge. Entry layout: bits 7:0 are the character, bit 8 is framing, bit 9 is parity, bit 10 is break and bit 11 is overrun.
- R7: A break event stores the entry 0x400.
- R8: A mode write with a new value empties the queue: `empty`=1, `irq`=0, `rx_ready`=1. A mode write with the same value changes nothing.
- R9: `irq` sets when the occupancy rises to 1 (the trigger level) and clears when a read brings it to 0.
- R10: A push and a pop in the same cycle keep the occupancy and flags. The popped entry leaves and the pushed entry joins at the tail.
- R11: Entries come out in arrival order, even when the write slot (read position plus count, modulo 16) wraps past slot 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fen_wr | input | 1 | Line-control write strobe |
| fen_wdata | input | 1 | Queue-enable value written by that strobe |
| push_valid | input | 1 | Receiver delivers a character |
| push_data | input | 8 | Received character |
| push_err | input | 4 | Error bits {overrun, break, parity, framing} |
| brk_event | input | 1 | Line break seen; takes priority over `push_valid` |
| pop | input | 1 | Data-register read strobe |
| rd_entry | output | 12 | Entry at the head of the queue |
| status | output | 4 | Error bits of the last entry read |
| rx_ready | output | 1 | Room for one more entry |
| full | output | 1 | Full flag |
| empty | output | 1 | Empty flag |
| irq | output | 1 | Receive-level interrupt request |
| ovr | output | 1 | One-cycle pulse: push refused |

## Verification
Wrong internal state shows at the ports within one clock. A miscounted occupancy moves `full`, `empty` or `rx_ready` off the expected cycle, either around the 16th push or at the last read. A bad read position or write slot shows on `rd_entry` at the next read, and it shows most plainly after the slot wraps. A lost flush leaves `empty` low in the cycle after the mode write. The bench checks each of these at the edge after the stimulus, in both modes.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;
    typedef enum logic [1:0] {
        Q_EMPTY = 2'd0,
        Q_PART  = 2'd1,
        Q_FULL  = 2'd2
    } occ_e;

    // receive-level trigger is fixed
    localparam int RX_TRIG = 1;
    // position of the break flag inside the error field
    localparam int BRK_POS = 2;
endpackage

// File: rtl/uart_rxq_store.sv
module uart_rxq_store #(
    parameter int DEPTH = 16,
    parameter int W     = 12,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_slot,
    input  logic [W-1:0]     wr_entry,
    input  logic [PTR_W-1:0] rd_pos,
    output logic [W-1:0]     rd_entry
);
    logic [W-1:0] slot_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
        end else if (wr_en) begin
            slot_q[wr_slot] <= wr_entry;
        end
    end

    assign rd_entry = slot_q[rd_pos];
endmodule

// File: rtl/uart_rxq_ptr.sv
module uart_rxq_ptr #(
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push_ok,
    input  logic             pop_ok,
    output logic [PTR_W-1:0] rd_pos,
    output logic [CNT_W-1:0] cnt,
    output logic [PTR_W-1:0] wr_slot
);
    // modulo-DEPTH wrap relies on DEPTH being a power of two
    assign wr_slot = rd_pos + cnt[PTR_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_pos <= '0;
            cnt    <= '0;
        end else if (flush) begin
            rd_pos <= '0;
            cnt    <= '0;
        end else begin
            if (pop_ok) rd_pos <= rd_pos + PTR_W'(1);
            unique case ({push_ok, pop_ok})
                2'b10:   cnt <= cnt + CNT_W'(1);
                2'b01:   cnt <= cnt - CNT_W'(1);
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/uart_rxq_ctrl.sv
module uart_rxq_ctrl
    import uart_rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int ERR_W = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fen_wr,
    input  logic             fen_wdata,
    input  logic             push_req,
    input  logic             pop,
    input  logic [CNT_W-1:0] cnt,
    input  logic [ERR_W-1:0] head_err,
    output logic             flush,
    output logic             push_ok,
    output logic             pop_ok,
    output logic             rx_ready,
    output logic             full,
    output logic             empty,
    output logic             irq,
    output logic [ERR_W-1:0] status,
    output logic             ovr
);
    localparam logic [CNT_W-1:0] CAP_QUEUE = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] CAP_ONE   = CNT_W'(1);
    localparam logic [CNT_W-1:0] TRIG      = CNT_W'(RX_TRIG);

    logic             fen_q;
    logic [CNT_W-1:0] cap;
    occ_e             st_q, st_d;

    assign cap      = fen_q ? CAP_QUEUE : CAP_ONE;
    assign rx_ready = (cnt < cap);
    assign flush    = fen_wr && (fen_wdata != fen_q);
    assign push_ok  = push_req && rx_ready && !flush;
    assign pop_ok   = pop && (cnt != '0) && !flush;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      fen_q <= 1'b0;
        else if (fen_wr) fen_q <= fen_wdata;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= Q_EMPTY;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d = Q_EMPTY;                                    // flush
        end else begin
            unique case (st_q)
                Q_EMPTY: if (push_ok)                          // fill
                    st_d = (cap == CAP_ONE) ? Q_FULL : Q_PART;
                Q_PART: begin
                    if (push_ok && !pop_ok && (cnt + CNT_W'(1) == cap))
                        st_d = Q_FULL;                         // top-up
                    else if (pop_ok && !push_ok && (cnt == CNT_W'(1)))
                        st_d = Q_EMPTY;                        // drain
                end
                Q_FULL: if (pop_ok && !push_ok)                // unload
                    st_d = (cap == CAP_ONE) ? Q_EMPTY : Q_PART;
                default: st_d = Q_EMPTY;
            endcase
        end
    end

    // flag outputs decoded from the state
    always_comb begin
        full  = (st_q == Q_FULL);
        empty = (st_q == Q_EMPTY);
    end

    // registered outputs: interrupt level, status latch, overrun pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq    <= 1'b0;
            status <= '0;
            ovr    <= 1'b0;
        end else begin
            ovr <= push_req && !rx_ready && !flush;
            if (pop) status <= head_err;
            if (flush)
                irq <= 1'b0;
            else if (push_ok && !pop_ok && (cnt + CNT_W'(1) == TRIG))
                irq <= 1'b1;
            else if (pop_ok && !push_ok && (cnt == TRIG))
                irq <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_rxq.sv
module uart_rxq
    import uart_rxq_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8,
    parameter int ERR_W  = 4,
    localparam int ENT_W = DATA_W + ERR_W,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fen_wr,
    input  logic              fen_wdata,
    input  logic              push_valid,
    input  logic [DATA_W-1:0] push_data,
    input  logic [ERR_W-1:0]  push_err,
    input  logic              brk_event,
    input  logic              pop,
    output logic [ENT_W-1:0]  rd_entry,
    output logic [ERR_W-1:0]  status,
    output logic              rx_ready,
    output logic              full,
    output logic              empty,
    output logic              irq,
    output logic              ovr
);
    localparam logic [ENT_W-1:0] BRK_ENTRY = {ERR_W'(1 << BRK_POS), DATA_W'(0)};

    logic             push_req, push_ok, pop_ok, flush;
    logic [ENT_W-1:0] wr_entry;
    logic [PTR_W-1:0] rd_pos, wr_slot;
    logic [CNT_W-1:0] cnt;

    assign push_req = push_valid || brk_event;
    assign wr_entry = brk_event ? BRK_ENTRY : {push_err, push_data};

    uart_rxq_store #(.DEPTH(DEPTH), .W(ENT_W)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(push_ok), .wr_slot(wr_slot),
        .wr_entry(wr_entry), .rd_pos(rd_pos), .rd_entry(rd_entry)
    );

    uart_rxq_ptr #(.DEPTH(DEPTH)) u_ptr (
        .clk(clk), .rst_n(rst_n), .flush(flush), .push_ok(push_ok),
        .pop_ok(pop_ok), .rd_pos(rd_pos), .cnt(cnt), .wr_slot(wr_slot)
    );

    uart_rxq_ctrl #(.DEPTH(DEPTH), .ERR_W(ERR_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .fen_wr(fen_wr), .fen_wdata(fen_wdata),
        .push_req(push_req), .pop(pop), .cnt(cnt),
        .head_err(rd_entry[ENT_W-1:DATA_W]), .flush(flush),
        .push_ok(push_ok), .pop_ok(pop_ok), .rx_ready(rx_ready),
        .full(full), .empty(empty), .irq(irq), .status(status), .ovr(ovr)
    );
endmodule

// File: rtl/uart_rxq_chk.sv
module uart_rxq_chk #(
    parameter int ENT_W = 12,
    parameter int ERR_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             push_req,
    input logic             pop,
    input logic             flush,
    input logic             push_ok,
    input logic             pop_ok,
    input logic             rx_ready,
    input logic             full,
    input logic             empty,
    input logic             irq,
    input logic             ovr,
    input logic [ERR_W-1:0] status,
    input logic [ENT_W-1:0] rd_entry
);
    // R3
    full_blocks_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !rx_ready);

    // R2
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

    // R9
    irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq == !empty);

    // R4
    overrun_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_req && !rx_ready && !flush |=> ovr);

    // R5
    empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop && empty && !push_req && !flush |=> empty && $stable(rd_entry));

    // R6
    status_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> status == $past(rd_entry[ENT_W-1:ENT_W-ERR_W]));

    // R8
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty && !irq && rx_ready);

    // R10
    pushpop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_ok && pop_ok |=> $stable(full) && $stable(empty));
endmodule

bind uart_rxq uart_rxq_chk #(.ENT_W(ENT_W), .ERR_W(ERR_W)) u_rxq_chk (
    .clk(clk), .rst_n(rst_n), .push_req(push_req), .pop(pop), .flush(flush),
    .push_ok(push_ok), .pop_ok(pop_ok), .rx_ready(rx_ready), .full(full),
    .empty(empty), .irq(irq), .ovr(ovr), .status(status), .rd_entry(rd_entry)
);

// File: tb/uart_rxq_bench.sv
module uart_rxq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fen_wr = 1'b0, fen_wdata = 1'b0;
    logic        push_valid = 1'b0, brk_event = 1'b0, pop = 1'b0;
    logic [7:0]  push_data = '0;
    logic [3:0]  push_err = '0;
    logic [11:0] rd_entry;
    logic [3:0]  status;
    logic        rx_ready, full, empty, irq, ovr;

    int n_chk = 0;
    int n_bad = 0;
    logic [11:0] prev;

    always #10 clk = ~clk;   // 50 MHz

    uart_rxq u_uart_rxq (
        .clk(clk), .rst_n(rst_n), .fen_wr(fen_wr), .fen_wdata(fen_wdata),
        .push_valid(push_valid), .push_data(push_data), .push_err(push_err),
        .brk_event(brk_event), .pop(pop), .rd_entry(rd_entry),
        .status(status), .rx_ready(rx_ready), .full(full), .empty(empty),
        .irq(irq), .ovr(ovr)
    );

    // {push, pop, err[3:0], data[7:0], exp_entry[11:0], exp_empty, exp_full, exp_irq}
    localparam logic [28:0] VECS [7] = '{
        {1'b1, 1'b0, 4'h0, 8'hA5, 12'h0A5, 1'b0, 1'b0, 1'b1},
        {1'b1, 1'b0, 4'h1, 8'h3C, 12'h0A5, 1'b0, 1'b0, 1'b1},
        {1'b1, 1'b1, 4'h2, 8'h77, 12'h13C, 1'b0, 1'b0, 1'b1},
        {1'b0, 1'b1, 4'h0, 8'h00, 12'h277, 1'b0, 1'b0, 1'b1},
        {1'b0, 1'b1, 4'h0, 8'h00, 12'h000, 1'b1, 1'b0, 1'b0},
        {1'b1, 1'b0, 4'h8, 8'h11, 12'h811, 1'b0, 1'b0, 1'b1},
        {1'b0, 1'b1, 4'h0, 8'h00, 12'h000, 1'b1, 1'b0, 1'b0}
    };

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input logic p, input logic pp, input logic b,
                        input logic [3:0] e, input logic [7:0] d,
                        input logic fw, input logic fv);
        @(negedge clk);
        push_valid = p; pop = pp; brk_event = b; push_err = e; push_data = d;
        fen_wr = fw; fen_wdata = fv;
        @(posedge clk);
        #2;
    endtask

    task automatic idle();
        step(1'b0, 1'b0, 1'b0, 4'h0, 8'h00, 1'b0, 1'b0);
    endtask

    initial begin
        #(20 * 100000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #2;
        // R1 reset state
        chk(empty, 1, "R1 empty"); chk(full, 0, "R1 full"); chk(irq, 0, "R1 irq");
        chk(rx_ready, 1, "R1 ready"); chk(ovr, 0, "R1 ovr"); chk(status, 0, "R1 status");

        // R3 single-entry mode
        step(1, 0, 0, 4'h0, 8'h42, 0, 0);
        chk(full, 1, "R3 full after one push"); chk(rx_ready, 0, "R3 ready low");
        chk(irq, 1, "R9 irq on first entry");
        // R4 refused push
        step(1, 0, 0, 4'h0, 8'h55, 0, 0);
        chk(ovr, 1, "R4 ovr pulse"); chk(rd_entry, 12'h042, "R4 content kept");
        idle();
        chk(ovr, 0, "R4 ovr one cycle");
        step(0, 1, 0, 4'h0, 8'h00, 0, 0);
        chk(full, 0, "R3 read clears full"); chk(empty, 1, "R3 empty after read");
        chk(irq, 0, "R9 irq clears at zero"); chk(status, 0, "R6 clean status");

        // R7 break entry
        step(0, 0, 1, 4'h0, 8'hFF, 0, 0);
        chk(rd_entry, 12'h400, "R7 break entry");
        step(0, 1, 0, 4'h0, 8'h00, 0, 0);
        chk(status, 4'h4, "R6 break status");
        step(1, 0, 0, 4'h3, 8'h9E, 0, 0);
        chk(rd_entry, 12'h39E, "R6 entry with errors");
        step(0, 1, 0, 4'h0, 8'h00, 0, 0);
        chk(status, 4'h3, "R6 framing+parity status");

        // R5 read while empty
        prev = rd_entry;
        step(0, 1, 0, 4'h0, 8'h00, 0, 0);
        chk(rd_entry, prev, "R5 head unchanged"); chk(empty, 1, "R5 still empty");
        chk(rx_ready, 1, "R5 still ready");

        // R8 switch to queue mode flushes
        step(0, 0, 0, 4'h0, 8'h00, 1, 1);
        chk(empty, 1, "R8 empty after mode change"); chk(rx_ready, 1, "R8 ready");

        // vector table, queue mode (R10 in third row)
        foreach (VECS[i]) begin
            step(VECS[i][28], VECS[i][27], 0, VECS[i][26:23], VECS[i][22:15], 0, 0);
            if (!VECS[i][2]) chk(rd_entry, VECS[i][14:3], "R10 table head");
            chk(empty, VECS[i][2], "R10 table empty");
            chk(full,  VECS[i][1], "R2 table full");
            chk(irq,   VECS[i][0], "R9 table irq");
        end
        chk(status, 4'h8, "R6 overrun status");

        // R2 / R11 fill 16 across the slot wrap (read position is 4)
        for (int i = 0; i < 16; i++) begin
            step(1, 0, 0, 4'h0, 8'(8'h20 + i), 0, 0);
            if (i == 14) begin
                chk(full, 0, "R2 not full at 15"); chk(rx_ready, 1, "R2 ready at 15");
            end
        end
        chk(full, 1, "R2 full at 16"); chk(rx_ready, 0, "R2 ready low at 16");
        step(1, 0, 0, 4'h0, 8'hEE, 0, 0);
        chk(ovr, 1, "R4 ovr when queue full");
        for (int i = 0; i < 16; i++) begin
            chk(rd_entry, 12'(12'h020 + i), "R11 arrival order");
            step(0, 1, 0, 4'h0, 8'h00, 0, 0);
        end
        chk(empty, 1, "R11 drained");

        // R8 same value keeps contents, new value flushes
        step(1, 0, 0, 4'h0, 8'h61, 0, 0);
        step(1, 0, 0, 4'h0, 8'h62, 0, 0);
        step(0, 0, 0, 4'h0, 8'h00, 1, 1);
        chk(empty, 0, "R8 same value no flush"); chk(rd_entry, 12'h061, "R8 head kept");
        step(0, 0, 0, 4'h0, 8'h00, 1, 0);
        chk(empty, 1, "R8 flush empty"); chk(irq, 0, "R8 flush irq");
        chk(rx_ready, 1, "R8 flush ready");
        step(1, 0, 0, 4'h0, 8'h70, 0, 0);
        chk(full, 1, "R3 single mode again");
        idle();

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule